// File: doc/BRIEF.md
# Banked Working-Register File with Upward Stack

This block holds the 256-byte internal data memory of a small 8-bit controller core, together with the 8-bit stack pointer that walks through it. A core uses it in three ways in the same cycle. It reaches the eight working registers through a 3-bit register index and a 2-bit bank field that picks one of four 8-byte windows at the bottom of the memory. It pushes and pops bytes through a stack that grows toward higher addresses. It reads and writes any byte through a direct address port.

Every read is combinational from the array, so the register value, the byte at the top of the stack and the directly addressed byte all follow their address inputs within the same cycle. Writes and stack-pointer moves take effect on the rising clock edge. When several writes land on one byte in the same cycle, a fixed priority decides which value is kept.

Top module: `iram_stack_bank`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `sp` reads 07h and every one of the 256 bytes reads 00h.
- R2: A push (`push`=1, `pop`=0) raises `sp` by one at the clock edge and stores `push_data` at the new `sp` value. The first push after reset therefore stores its byte at 08h.
- R3: `pop_data` always shows the byte at address `sp`. A pop (`pop`=1, `push`=0) lowers `sp` by one at the clock edge, so the popped byte is the one shown before that edge.
- R4: `sp` wraps modulo 256 with no fault signal: a push at FFh moves it to 00h and stores at 00h, and a pop at 00h moves it to FFh.
- R5: Working register n in bank b sits at byte address b*8 + n. Bank 0 covers 00h–07h, bank 1 covers 08h–0Fh, bank 2 covers 10h–17h and bank 3 covers 18h–1Fh.
- R6: `reg_rdata` shows the addressed working register combinationally. A `reg_we` pulse stores `reg_wdata` there at the clock edge.
- R7: `dir_rdata` shows the byte at `dir_addr` combinationally. A `dir_we` pulse stores `dir_wdata` at any of the 256 addresses at the clock edge.
- R8: When writes collide on one byte in the same cycle, the push value is kept over the register write, and the register write is kept over the direct write.
- R9: When `push` and `pop` are both high in a cycle, `sp` does not change and no stack byte is written.
- R10: Writes to different bytes in the same cycle (push, register and direct) all take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_idx | input | 3 | Working register number 0–7 |
| bank_sel | input | 2 | Register bank 0–3 |
| reg_we | input | 1 | Write strobe for the addressed working register |
| reg_wdata | input | 8 | Working register write data |
| reg_rdata | output | 8 | Addressed working register value |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | Byte at the top of the stack |
| sp | output | 8 | Current stack pointer |
| dir_addr | input | 8 | Direct access address |
| dir_we | input | 1 | Direct write strobe |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Byte at `dir_addr` |

## Verification
The assertions assume that every input is driven to a known 0 or 1 on every clock edge after reset. They also assume that the register index and bank stay the same across a cycle whenever the register write-back check is meant to apply. The properties guard that case in their own antecedent. The stimulus drives every input from time zero. It mixes directed collisions, pointer wraps and simultaneous push and pop with a long stretch of random operations. Because the random stretch changes the index and bank freely, the write-back property only fires on the cycles where they happen to stay the same.

// File: rtl/iram_pkg.sv
package iram_pkg;
  parameter int unsigned IRAM_AW   = 8;
  parameter int unsigned IRAM_DW   = 8;
  parameter int unsigned IDX_W     = 3;
  parameter int unsigned BANK_W    = 2;
  parameter int unsigned IRAM_DEPTH = 1 << IRAM_AW;

  typedef logic [IRAM_AW-1:0] iaddr_t;
  typedef logic [IRAM_DW-1:0] ibyte_t;

  typedef enum logic [1:0] {
    SOP_NONE = 2'd0,
    SOP_PUSH = 2'd1,
    SOP_POP  = 2'd2
  } stack_op_e;

  // Bank-relative register address: zero-padded {bank, index}.
  function automatic iaddr_t bank_reg_addr(input logic [BANK_W-1:0] bank,
                                           input logic [IDX_W-1:0] idx);
    iaddr_t a;
    a = '0;
    a[IDX_W +: BANK_W] = bank;
    a[IDX_W-1:0]       = idx;
    return a;
  endfunction

  // Stack pointer step, wraps modulo the address space.
  function automatic iaddr_t sp_step(input iaddr_t cur, input stack_op_e op);
    case (op)
      SOP_PUSH: return cur + iaddr_t'(1);
      SOP_POP:  return cur - iaddr_t'(1);
      default:  return cur;
    endcase
  endfunction

  // Push and pop in the same cycle cancel each other.
  function automatic stack_op_e decode_op(input logic psh, input logic pp);
    if (psh && !pp) return SOP_PUSH;
    if (pp && !psh) return SOP_POP;
    return SOP_NONE;
  endfunction
endpackage

// File: rtl/iram_sp_ctrl.sv
module iram_sp_ctrl
  import iram_pkg::*;
#(
  parameter int unsigned AW     = IRAM_AW,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stack_op_e     op,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] push_addr
);
  logic [AW-1:0] sp_d;

  always_comb begin
    sp_d      = sp_step(sp_q, op);
    push_addr = sp_step(sp_q, SOP_PUSH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RST;
    else        sp_q <= sp_d;
  end
endmodule

// File: rtl/iram_array.sv
module iram_array
  import iram_pkg::*;
#(
  parameter int unsigned AW    = IRAM_AW,
  parameter int unsigned DW    = IRAM_DW,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  // write requests, listed from highest to lowest priority
  input  logic          push_we,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_wdata,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          dir_we,
  input  logic [AW-1:0] dir_addr,
  input  logic [DW-1:0] dir_wdata,
  // combinational read ports
  input  logic [AW-1:0] rd_top_addr,
  output logic [DW-1:0] rd_top_data,
  output logic [DW-1:0] rd_reg_data,
  output logic [DW-1:0] rd_dir_data
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic hit_push, hit_reg, hit_dir;
    assign hit_push = push_we && (push_addr == AW'(g));
    assign hit_reg  = reg_we  && (reg_addr  == AW'(g));
    assign hit_dir  = dir_we  && (dir_addr  == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem[g] <= '0;
      else if (hit_push) mem[g] <= push_wdata;
      else if (hit_reg)  mem[g] <= reg_wdata;
      else if (hit_dir)  mem[g] <= dir_wdata;
    end
  end

  assign rd_top_data = mem[rd_top_addr];
  assign rd_reg_data = mem[reg_addr];
  assign rd_dir_data = mem[dir_addr];
endmodule

// File: rtl/iram_stack_bank.sv
module iram_stack_bank
  import iram_pkg::*;
#(
  parameter int unsigned AW     = IRAM_AW,
  parameter int unsigned DW     = IRAM_DW,
  parameter int unsigned IW     = IDX_W,
  parameter int unsigned BW     = BANK_W,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reg_idx,
  input  logic [BW-1:0] bank_sel,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic [AW-1:0] sp,
  input  logic [AW-1:0] dir_addr,
  input  logic          dir_we,
  input  logic [DW-1:0] dir_wdata,
  output logic [DW-1:0] dir_rdata
);
  // named internal events, also observed by the bound checker
  stack_op_e     stk_op;
  logic          push_go;
  logic          pop_go;
  logic [AW-1:0] push_addr;
  logic [AW-1:0] reg_addr;

  assign stk_op   = decode_op(push, pop);
  assign push_go  = (stk_op == SOP_PUSH);
  assign pop_go   = (stk_op == SOP_POP);
  assign reg_addr = AW'(bank_reg_addr(bank_sel, reg_idx));

  iram_sp_ctrl #(.AW(AW), .SP_RST(SP_RST)) i_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (stk_op),
    .sp_q      (sp),
    .push_addr (push_addr)
  );

  iram_array #(.AW(AW), .DW(DW)) i_ram (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_we     (push_go),
    .push_addr   (push_addr),
    .push_wdata  (push_data),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .dir_we      (dir_we),
    .dir_addr    (dir_addr),
    .dir_wdata   (dir_wdata),
    .rd_top_addr (sp),
    .rd_top_data (pop_data),
    .rd_reg_data (reg_rdata),
    .rd_dir_data (dir_rdata)
  );
endmodule

// File: rtl/iram_stack_bank_chk.sv
module iram_stack_bank_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 3,
  parameter int unsigned BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] sp,
  input logic [DW-1:0] pop_data,
  input logic [DW-1:0] push_data,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] reg_wdata,
  input logic          reg_we,
  input logic [IW-1:0] reg_idx,
  input logic [BW-1:0] bank_sel,
  input logic          push_go,
  input logic          pop_go,
  input logic [AW-1:0] push_addr,
  input logic [AW-1:0] reg_addr
);
  // R2: push raises the pointer by one
  p_sp_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> sp == AW'($past(sp) + 1'b1));

  // R2: the pushed byte is at the top of the stack afterwards
  p_push_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> pop_data == $past(push_data));

  // R3: pop lowers the pointer by one
  p_sp_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_go |=> sp == AW'($past(sp) - 1'b1));

  // R4: wrap from the top of memory
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_go && sp == '1) |=> sp == '0);

  // R9: no stack move leaves the pointer alone
  p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_go && !pop_go) |=> $stable(sp));

  // R6: a register write not overruled by a push reads back next cycle
  p_reg_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !(push_go && push_addr == reg_addr)) ##1
      ($stable(reg_idx) && $stable(bank_sel)) |-> reg_rdata == $past(reg_wdata));
endmodule

bind iram_stack_bank iram_stack_bank_chk #(.AW(AW), .DW(DW), .IW(IW), .BW(BW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sp        (sp),
  .pop_data  (pop_data),
  .push_data (push_data),
  .reg_rdata (reg_rdata),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .reg_idx   (reg_idx),
  .bank_sel  (bank_sel),
  .push_go   (push_go),
  .pop_go    (pop_go),
  .push_addr (push_addr),
  .reg_addr  (reg_addr)
);

// File: tb/test_iram_stack_bank.sv
`timescale 1ns/1ps
module test_iram_stack_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [1:0] bank_sel = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data, sp;
  logic [7:0] dir_addr = '0;
  logic       dir_we = 1'b0;
  logic [7:0] dir_wdata = '0;
  logic [7:0] dir_rdata;

  int vectors = 0;
  int miscmp = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  iram_stack_bank i_iram_stack_bank (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .bank_sel(bank_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .push(push), .pop(pop), .push_data(push_data), .pop_data(pop_data),
    .sp(sp), .dir_addr(dir_addr), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .dir_rdata(dir_rdata)
  );

  // behavioural reference model
  int m_mem [256];
  int m_sp;

  function automatic int reg_loc(input int b, input int n);
    return b * 8 + n;
  endfunction

  task automatic model_reset();
    foreach (m_mem[i]) m_mem[i] = 0;
    m_sp = 7;
  endtask

  task automatic model_clock();
    int tgt;
    if (!rst_n) begin model_reset(); return; end
    // lowest priority first, so later writes win (R8)
    if (dir_we) m_mem[dir_addr] = dir_wdata;
    if (reg_we) m_mem[reg_loc(bank_sel, reg_idx)] = reg_wdata;
    if (push && !pop) begin
      tgt = (m_sp + 1) % 256;
      m_mem[tgt] = push_data;
      m_sp = tgt;
    end else if (pop && !push) begin
      m_sp = (m_sp + 255) % 256;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input string tag);
    @(negedge clk);
    chk(tag, "sp", sp, m_sp);
    chk(tag, "pop_data", pop_data, m_mem[m_sp]);
    chk(tag, "reg_rdata", reg_rdata, m_mem[reg_loc(bank_sel, reg_idx)]);
    chk(tag, "dir_rdata", dir_rdata, m_mem[dir_addr]);
    @(posedge clk);
    model_clock();
    #1;
  endtask

  task automatic idle();
    push = 0; pop = 0; reg_we = 0; dir_we = 0;
  endtask

  initial begin
    model_reset();
    // R1: reset state
    for (int i = 0; i < 4; i++) begin dir_addr = 8'(i * 8); apply("R1"); end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    for (int a = 0; a < 256; a++) begin dir_addr = 8'(a); apply("R1"); end

    // R2: first push lands at 08h
    dir_addr = 8'h08;
    for (int k = 0; k < 3; k++) begin
      push = 1; push_data = 8'(8'h41 + k); apply("R2");
    end
    idle(); apply("R2");
    dir_addr = 8'h0A; apply("R2");

    // R3: pops expose then step down
    for (int k = 0; k < 3; k++) begin pop = 1; apply("R3"); end
    idle(); apply("R3");

    // R5, R6: every bank and register
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 8; n++) begin
        bank_sel = 2'(b); reg_idx = 3'(n); reg_we = 1;
        reg_wdata = 8'(8'h80 + b * 8 + n); dir_addr = 8'(b * 8 + n);
        apply("R6");
        reg_we = 0; apply("R5");
      end

    // R7: direct writes across the range
    for (int a = 0; a < 256; a += 37) begin
      dir_addr = 8'(a); dir_we = 1; dir_wdata = 8'(a ^ 8'h5A); apply("R7");
      dir_we = 0; apply("R7");
    end

    // R8: push vs register vs direct on 08h (sp is 07h)
    push = 1; push_data = 8'hAA;
    bank_sel = 2'd1; reg_idx = 3'd0; reg_we = 1; reg_wdata = 8'hBB;
    dir_addr = 8'h08; dir_we = 1; dir_wdata = 8'hCC;
    apply("R8");
    idle(); apply("R8");
    // register vs direct on 13h
    bank_sel = 2'd2; reg_idx = 3'd3; reg_we = 1; reg_wdata = 8'h11;
    dir_addr = 8'h13; dir_we = 1; dir_wdata = 8'h22;
    apply("R8");
    idle(); apply("R8");

    // R9: push with pop
    push = 1; pop = 1; push_data = 8'hEE; dir_addr = 8'h09; apply("R9");
    idle(); apply("R9");

    // R10: distinct targets in one cycle
    push = 1; push_data = 8'h31;
    bank_sel = 2'd3; reg_idx = 3'd7; reg_we = 1; reg_wdata = 8'h32;
    dir_addr = 8'hC0; dir_we = 1; dir_wdata = 8'h33;
    apply("R10");
    idle(); apply("R10");

    // R4: climb through FFh and back
    for (int k = 0; k < 260; k++) begin
      push = 1; push_data = 8'(k); dir_addr = 8'h00; apply("R4");
    end
    idle();
    for (int k = 0; k < 8; k++) begin pop = 1; apply("R4"); end
    idle(); apply("R4");

    // R10: random mix
    for (int k = 0; k < 2000; k++) begin
      push = $urandom_range(0, 1) == 1; pop = $urandom_range(0, 2) == 0;
      push_data = 8'($urandom); reg_we = $urandom_range(0, 1) == 1;
      reg_wdata = 8'($urandom); bank_sel = 2'($urandom); reg_idx = 3'($urandom);
      dir_we = $urandom_range(0, 2) == 0; dir_wdata = 8'($urandom);
      dir_addr = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 31)) : 8'($urandom);
      apply("R10");
    end
    idle(); apply("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule